// File: doc/BRIEF.md
# Bus-Stall Timeout Watchdog

This block guards a serial-bus controller against hanging forever between events. The controller raises an event flag each time it has a new bus state to report; software services the event and lowers the flag. While the flag is low the bus is expected to produce the next event soon. This watchdog counts clock cycles during that wait. If the wait lasts long enough to wrap a 14-bit counter, it raises a sticky timeout flag and an interrupt request. An optional prescaler makes the counter advance only every fourth clock, so the window is four times longer.

Counting is steered by a four-state machine. ST_OFF: the enable is low, and the counter and prescaler are held at zero. ST_WAIT: the watchdog is enabled but has not yet seen the event flag high, so it does not count. ST_HOLD: the event flag is high, and the counter is held at zero. ST_RUN: the flag has dropped after being high, and the counter advances. The transitions are as follows. Any state goes to ST_OFF when the enable is low; this takes priority over the rest. ST_OFF goes to ST_HOLD if the flag is high, otherwise to ST_WAIT. ST_WAIT goes to ST_HOLD on a high flag. ST_HOLD goes to ST_RUN on a low flag. ST_RUN goes to ST_HOLD on a high flag. Otherwise every state stays where it is.

Top module: `bus_stall_watchdog`

## Requirements
- R1: After reset, `tmo_flag`, `tmo_irq` and `tmo_count` are all zero.
- R2: With `tmo_en` high, counting starts only after `ctl_flag` has been seen high and then low. Enabling while `ctl_flag` is already low leaves the count at zero. In normal mode the count is 0 after the first clock edge with `ctl_flag` low, and it then rises by one on each further edge. For example, ten edges after the flag drops, the count reads 9.
- R3: While `ctl_flag` is high, the count is forced to zero and held there. Once the flag drops again, counting restarts from zero.
- R4: When the count wraps from 16383 to 0, `tmo_flag` is set on that same edge, and counting continues from 0. In normal mode the flag is first seen high 16385 edges after the flag drops.
- R5: With `slow_sel` high, the count advances once every four clocks. The prescaler is cleared with the counter, so the count first reads 1 five edges after the flag drops. The timeout flag first reads high 65537 edges after the flag drops.
- R6: `tmo_flag` is sticky. A high `tmo_clr` clears it on the next edge. If a wrap and `tmo_clr` occur on the same edge, the flag is set.
- R7: With `tmo_en` low, the count stays at zero and `tmo_flag` is never set. A flag that is already set stays set.
- R8: `tmo_irq` is high exactly when both `tmo_flag` and `tmo_en` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_flag | input | 1 | Event flag of the watched bus controller |
| tmo_en | input | 1 | Watchdog enable |
| slow_sel | input | 1 | Select prescale by four |
| tmo_clr | input | 1 | Write-one-to-clear strobe for the timeout flag |
| tmo_flag | output | 1 | Sticky timeout flag |
| tmo_irq | output | 1 | Interrupt request, the timeout flag gated by the enable |
| tmo_count | output | 14 | Current count, for debug |

## Verification
A wrong state (for example ST_RUN entered straight from ST_WAIT) shows on `tmo_count` one clock later as a non-zero value where zero was expected. The bench compares the count with a reference model at every clock, so such an error appears at once rather than only at the end of a timeout. A prescaler that is off in phase shifts the first increment by up to three clocks, and the directed check five edges after the flag drops catches it. Errors in the flag path are different: a wrong wrap edge or a wrong set-versus-clear priority shows only at the wrap boundary. The bench therefore samples the edge just before and the edge just after the wrap, and lines up a clear strobe with that edge.

// File: rtl/stall_wd_pkg.sv
package stall_wd_pkg;
    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_WAIT = 2'd1,
        ST_HOLD = 2'd2,
        ST_RUN  = 2'd3
    } wd_state_e;
endpackage

// File: rtl/stall_wd_fsm.sv
module stall_wd_fsm
    import stall_wd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic evt_flag,
    output logic run_go
);
    wd_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (!en) begin
            state_d = ST_OFF;
        end else begin
            unique case (state_q)
                ST_OFF:  state_d = evt_flag ? ST_HOLD : ST_WAIT;
                ST_WAIT: if (evt_flag) state_d = ST_HOLD;
                ST_HOLD: if (!evt_flag) state_d = ST_RUN;
                ST_RUN:  if (evt_flag) state_d = ST_HOLD;
                default: state_d = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // output decode: advance only in RUN while inputs still allow it
    always_comb begin
        run_go = 1'b0;
        unique case (state_q)
            ST_RUN:  run_go = en && !evt_flag;
            default: run_go = 1'b0;
        endcase
    end

    assert_off_when_disabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> state_q == ST_OFF);
    assert_wait_no_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT) && en && !evt_flag |=> state_q == ST_WAIT);
    assert_flag_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        en && evt_flag |=> state_q == ST_HOLD);
endmodule

// File: rtl/stall_wd_prescaler.sv
module stall_wd_prescaler #(
    parameter int PRE_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_go,
    input  logic slow_sel,
    output logic tick
);
    generate
        if (PRE_DIV > 1) begin : g_div
            localparam int PRE_W = $clog2(PRE_DIV);
            localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRE_DIV - 1);
            logic [PRE_W-1:0] pre_q;
            logic             at_last;

            assign at_last = (pre_q == PRE_LAST);
            assign tick    = run_go && (!slow_sel || at_last);

            always_ff @(posedge clk) begin
                if (!rst_n || !run_go || !slow_sel) pre_q <= '0;
                else if (at_last)                   pre_q <= '0;
                else                                pre_q <= pre_q + 1'b1;
            end

            assert_first_tick_late_R5: assert property (@(posedge clk) disable iff (!rst_n)
                slow_sel && run_go && !$past(run_go) |-> !tick);
        end else begin : g_nodiv
            assign tick = run_go;
        end
    endgenerate
endmodule

// File: rtl/stall_wd_counter.sv
module stall_wd_counter #(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_go,
    input  logic             tick,
    output logic [CNT_W-1:0] count,
    output logic             wrap
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !run_go) cnt_q <= '0;
        else if (tick)         cnt_q <= cnt_q + 1'b1;
    end

    assign wrap  = tick && (cnt_q == CNT_MAX);
    assign count = cnt_q;

    assert_clear_when_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !run_go |=> cnt_q == '0);
    assert_step_by_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
        run_go && tick |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));
    assert_hold_between_ticks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        run_go && !tick |=> $stable(cnt_q));
endmodule

// File: rtl/stall_wd_flag.sv
module stall_wd_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic wrap,
    input  logic clr,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (!rst_n)    flag <= 1'b0;
        else if (wrap) flag <= 1'b1;
        else if (clr)  flag <= 1'b0;
    end

    assert_set_on_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> flag);
    assert_clear_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clr && !wrap |=> !flag);
    assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        flag && !clr |=> flag);
endmodule

// File: rtl/bus_stall_watchdog.sv
module bus_stall_watchdog #(
    parameter int CNT_W   = 14,
    parameter int PRE_DIV = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_flag,
    input  logic             tmo_en,
    input  logic             slow_sel,
    input  logic             tmo_clr,
    output logic             tmo_flag,
    output logic             tmo_irq,
    output logic [CNT_W-1:0] tmo_count
);
    logic run_go;
    logic tick;
    logic wrap;

    stall_wd_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (tmo_en),
        .evt_flag (ctl_flag),
        .run_go   (run_go)
    );

    stall_wd_prescaler #(.PRE_DIV(PRE_DIV)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_go   (run_go),
        .slow_sel (slow_sel),
        .tick     (tick)
    );

    stall_wd_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_go (run_go),
        .tick   (tick),
        .count  (tmo_count),
        .wrap   (wrap)
    );

    stall_wd_flag u_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .wrap  (wrap),
        .clr   (tmo_clr),
        .flag  (tmo_flag)
    );

    assign tmo_irq = tmo_flag && tmo_en;

    assert_no_set_when_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !tmo_en && !tmo_flag |=> !tmo_flag);
    assert_irq_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmo_irq) |-> tmo_en && tmo_flag);
endmodule

// File: tb/tb_bus_stall_watchdog.sv
module tb_bus_stall_watchdog;
    localparam int CW = 14;
    localparam int MAXC = (1 << CW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ctl_flag = 1'b0, tmo_en = 1'b0, slow_sel = 1'b0, tmo_clr = 1'b0;
    logic tmo_flag, tmo_irq;
    logic [CW-1:0] tmo_count;

    int n_checks = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    bus_stall_watchdog dut (
        .clk(clk), .rst_n(rst_n), .ctl_flag(ctl_flag), .tmo_en(tmo_en),
        .slow_sel(slow_sel), .tmo_clr(tmo_clr), .tmo_flag(tmo_flag),
        .tmo_irq(tmo_irq), .tmo_count(tmo_count)
    );

    // reference model built from the requirements
    bit m_hold, m_run, m_flag;
    int m_cnt, m_pre;

    function automatic int next_cnt(input int c, input bit adv);
        return adv ? ((c == MAXC) ? 0 : c + 1) : c;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_hold <= 0; m_run <= 0; m_flag <= 0; m_cnt <= 0; m_pre <= 0;
        end else begin
            bit counting, adv, wrapped;
            counting = m_run && tmo_en && !ctl_flag;
            adv = counting && (!slow_sel || m_pre == 3);
            wrapped = adv && (m_cnt == MAXC);
            if (counting) begin
                m_cnt <= next_cnt(m_cnt, adv);
                m_pre <= (slow_sel && m_pre != 3) ? m_pre + 1 : 0;
            end else begin
                m_cnt <= 0;
                m_pre <= 0;
            end
            if (wrapped) m_flag <= 1;
            else if (tmo_clr) m_flag <= 0;
            m_hold <= tmo_en && ctl_flag;
            m_run  <= tmo_en && !ctl_flag && (m_run || m_hold);
        end
    end

    function automatic bit exp_irq(input bit f, input bit e);
        return f && e;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // per-cycle comparison with the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R2/R3/R5 model count", int'(tmo_count), m_cnt);
            check("R4/R6 model flag", int'(tmo_flag), int'(m_flag));
            check("R8 model irq", int'(tmo_irq), int'(exp_irq(m_flag, tmo_en)));
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run;
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_checks++; n_err++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        void'($urandom(32'd1234));
        step(3);
        check("R1 reset count", int'(tmo_count), 0);
        check("R1 reset flag", int'(tmo_flag), 0);
        check("R1 reset irq", int'(tmo_irq), 0);
        rst_n = 1'b1;
        step(2);
        check("R1 after release", int'(tmo_count), 0);

        // R2: enable while flag already low: no counting
        tmo_en = 1; ctl_flag = 0;
        step(20);
        check("R2 no start without flag edge", int'(tmo_count), 0);

        // R3: flag high holds zero, then count restarts
        ctl_flag = 1; step(3);
        check("R3 held at zero", int'(tmo_count), 0);
        ctl_flag = 0; step(10);
        check("R2 count after ten edges", int'(tmo_count), 9);
        ctl_flag = 1; step(1);
        check("R3 forced to zero", int'(tmo_count), 0);
        ctl_flag = 0; step(5);
        check("R3 restart from zero", int'(tmo_count), 4);

        // R4: full timeout in normal mode
        ctl_flag = 1; step(1); ctl_flag = 0;
        step(16384);
        check("R4 before wrap count", int'(tmo_count), MAXC);
        check("R4 before wrap flag", int'(tmo_flag), 0);
        step(1);
        check("R4 flag on wrap", int'(tmo_flag), 1);
        check("R4 count wrapped", int'(tmo_count), 0);
        check("R8 irq with enable", int'(tmo_irq), 1);
        step(3);
        check("R4 counts on after wrap", int'(tmo_count), 3);

        // R7/R8: disable keeps flag, masks irq, stops count
        tmo_en = 0; step(2);
        check("R7 flag kept when disabled", int'(tmo_flag), 1);
        check("R8 irq masked", int'(tmo_irq), 0);
        check("R7 count zero when disabled", int'(tmo_count), 0);
        tmo_clr = 1; step(1); tmo_clr = 0;
        check("R6 clear strobe", int'(tmo_flag), 0);
        ctl_flag = 1; step(2); ctl_flag = 0; step(30);
        check("R7 no count when disabled", int'(tmo_count), 0);

        // R6: set wins over clear on the wrap edge
        tmo_en = 1; ctl_flag = 1; step(2); ctl_flag = 0;
        step(16384);
        tmo_clr = 1; step(1); tmo_clr = 0;
        check("R6 set beats clear", int'(tmo_flag), 1);
        tmo_clr = 1; step(1); tmo_clr = 0;
        check("R6 cleared afterwards", int'(tmo_flag), 0);

        // R5: divide by four
        slow_sel = 1; ctl_flag = 1; step(2); ctl_flag = 0;
        step(4);
        check("R5 no early increment", int'(tmo_count), 0);
        step(1);
        check("R5 first increment", int'(tmo_count), 1);
        step(65531);
        check("R5 before slow wrap count", int'(tmo_count), MAXC);
        check("R5 before slow wrap flag", int'(tmo_flag), 0);
        step(1);
        check("R5 flag after slow wrap", int'(tmo_flag), 1);
        tmo_clr = 1; step(1); tmo_clr = 0;

        // random phase, checked by the model
        for (int i = 0; i < 4000; i++) begin
            tmo_en   = (($urandom % 16) != 0);
            if (($urandom % 8) == 0) ctl_flag = ~ctl_flag;
            tmo_clr  = (($urandom % 32) == 0);
            if (($urandom % 64) == 0) slow_sel = ~slow_sel;
            step(1);
        end
        tmo_clr = 0;
        step(2);
        finish_run();
    end
endmodule